// File: doc/BRIEF.md
# Timer-Triggered DAC Output Sequencer

This block is the digital controller that sits in front of a multi-channel digital-to-analog core. Each channel has an enable, a mode select (software-paced or timer-paced), and a data register. The controller decides when a code is handed to the analog core. It counts out a power-up delay after every enable and a settling interval after every hand-off. It then raises a per-channel flag once the analog level can be trusted.

In software-paced mode, a write to the data register starts a conversion. A write made during the power-up delay is held and issued when the delay ends. In timer-paced mode, a pulse from an external timer channel starts each conversion with whatever code is current. A new pulse that lands inside the settling interval aborts the running conversion and starts over.

The block also owns the shared pin that each channel borrows from a general-purpose port. While a channel is on, the port cannot drive the pin, and port reads see a masked value. While it is off, the pin goes back to the port's direction and latch. Delays are parameters counted in clock cycles.

Top module: `dac_output_sequencer`

## Requirements
- R1: After reset, every channel reports core_load, busy, out_valid and dac_active as 0.
- R2: When ch_en rises, busy is 1 for exactly WAIT_CYC clock cycles. Timer pulses that arrive in that window start no conversion.
- R3: In software-paced mode (ch_rt = 0), writes made during the power-up delay are held. A single conversion of the most recent written code starts on the edge where the delay ends.
- R4: In software-paced mode after the delay, a write causes core_load = 1 with core_data equal to the written code in the following cycle. In that cycle busy is 1 and out_valid is 0.
- R5: out_valid rises exactly SETTLE_CYC cycles after the cycle in which core_load is 1, provided no new start intervenes. It stays 1 until the next start.
- R6: In timer-paced mode (ch_rt = 1), a write starts nothing. A trig pulse starts a conversion of the stored code.
- R7: A start that arrives while settling is still running, or after it has finished, clears out_valid, issues a fresh core_load and restarts the full settling interval.
- R8: When trig and a write to the same channel occur in one cycle, the code issued on core_data is the one written in that cycle.
- R9: Dropping ch_en for any time and raising it again restarts the full WAIT_CYC delay from the last rise.
- R10: With the channel off (dac_active = 0), busy and out_valid are 0, pin_oe follows port_dir_out, and pin_do equals port_latch when pin_oe is 1 and 0 otherwise.
- R11: With the channel on, pin_oe is 0 and port_rd returns port_latch for an output-direction bit and 0 for an input-direction bit.
- R12: With the channel off, port_rd returns port_latch for an output-direction bit and pin_in for an input-direction bit.
- R13: Channels are independent: activity on one channel causes no core_load or busy on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | NCH | Per-channel converter enable (level) |
| ch_rt | input | NCH | Per-channel mode: 1 = timer-paced, 0 = software-paced |
| wr_en | input | NCH | Per-channel data register write strobe |
| wr_data | input | NCH*DW | Write data, channel c in bits [c*DW +: DW] |
| trig | input | NCH | Timer pulse, one cycle per conversion request |
| port_dir_out | input | NCH | Port direction per pin: 1 = output, 0 = input |
| port_latch | input | NCH | Port output latch value per pin |
| pin_in | input | NCH | Level sampled from the pin |
| core_load | output | NCH | One-cycle pulse: analog core takes core_data |
| core_data | output | NCH*DW | Code handed to the analog core per channel |
| busy | output | NCH | Power-up delay or settling in progress |
| out_valid | output | NCH | Analog level has settled |
| dac_active | output | NCH | Converter owns the pin |
| pin_oe | output | NCH | Digital pin driver enable |
| pin_do | output | NCH | Digital pin driver value |
| port_rd | output | NCH | Value returned by a port data read |

## Verification
Software-paced conversions are swept over every code value of a narrow data width. Each one checks the issued code and the exact cycle in which out_valid rises. Held writes during the power-up delay show whether the latest code or an earlier one is issued. In timer-paced mode, a second pulse is placed at every offset from one cycle after a start to two cycles after settling ends. This separates an aborted conversion from a completed one being restarted, and each second pulse comes with a same-cycle write to show which code wins. All eight combinations of direction, latch and pin level are applied to one enabled and one disabled channel to separate pin ownership from port read masking.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

    typedef enum logic [2:0] {
        CH_OFF    = 3'd0,
        CH_WAIT   = 3'd1,
        CH_READY  = 3'd2,
        CH_SETTLE = 3'd3,
        CH_VALID  = 3'd4
    } ch_state_e;

    typedef struct packed {
        logic en;
        logic rt;
        logic wr;
        logic trig;
    } ch_ctl_t;

    function automatic int cnt_width(input int maxv);
        return (maxv < 1) ? 1 : $clog2(maxv + 1);
    endfunction

    function automatic logic state_busy(input ch_state_e s);
        return (s == CH_WAIT) || (s == CH_SETTLE);
    endfunction

endpackage

// File: rtl/dacseq_cnt.sv
module dacseq_cnt #(
    parameter int LOADV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic dec,
    output logic zero
);
    localparam int W = dacseq_pkg::cnt_width(LOADV);
    localparam logic [W-1:0] LV = W'(LOADV);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= LV;
        else if (dec && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/dacseq_chan.sv
module dacseq_chan
    import dacseq_pkg::*;
#(
    parameter int DW         = 12,
    parameter int WAIT_CYC   = 1000,
    parameter int SETTLE_CYC = 900
) (
    input  logic          clk,
    input  logic          rst,
    input  ch_ctl_t       ctl,
    input  logic [DW-1:0] wr_data,
    output ch_state_e     state,
    output logic          core_load,
    output logic [DW-1:0] core_data,
    output logic          busy,
    output logic          out_valid
);
    ch_state_e     state_q, state_d;
    logic [DW-1:0] data_q, eff_data, cdata_q;
    logic          pend_q, load_q;
    logic          wait_zero, settle_zero;
    logic          live, req, wait_done, start;

    assign eff_data  = ctl.wr ? wr_data : data_q;
    assign live      = (state_q == CH_READY) || (state_q == CH_SETTLE) || (state_q == CH_VALID);
    assign req       = ctl.rt ? ctl.trig : ctl.wr;
    assign wait_done = (state_q == CH_WAIT) && wait_zero;
    assign start     = ctl.en && ((live && req) ||
                                  (wait_done && !ctl.rt && (pend_q || ctl.wr)));

    dacseq_cnt #(.LOADV(WAIT_CYC - 1)) u_wait (
        .clk (clk),
        .rst (rst),
        .load(state_q == CH_OFF && ctl.en),
        .dec (state_q == CH_WAIT),
        .zero(wait_zero)
    );

    dacseq_cnt #(.LOADV(SETTLE_CYC - 1)) u_settle (
        .clk (clk),
        .rst (rst),
        .load(start),
        .dec (state_q == CH_SETTLE),
        .zero(settle_zero)
    );

    always_comb begin
        state_d = state_q;
        if (!ctl.en) begin
            state_d = CH_OFF;
        end else begin
            unique case (state_q)
                CH_OFF:    state_d = CH_WAIT;
                CH_WAIT:   if (wait_done) state_d = start ? CH_SETTLE : CH_READY;
                CH_READY:  if (start) state_d = CH_SETTLE;
                CH_SETTLE: if (start) state_d = CH_SETTLE;
                           else if (settle_zero) state_d = CH_VALID;
                CH_VALID:  if (start) state_d = CH_SETTLE;
                default:   state_d = CH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_OFF;
            data_q  <= '0;
            pend_q  <= 1'b0;
            load_q  <= 1'b0;
            cdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (ctl.wr)
                data_q <= ctl.wr ? wr_data : data_q;
            if (!ctl.en || start || wait_done)
                pend_q <= 1'b0;
            else if (ctl.wr && (state_q == CH_OFF || state_q == CH_WAIT))
                pend_q <= 1'b1;
            load_q <= start;
            if (start)
                cdata_q <= eff_data;
        end
    end

    assign state     = state_q;
    assign core_load = load_q;
    assign core_data = cdata_q;
    assign busy      = state_busy(state_q);
    assign out_valid = (state_q == CH_VALID);
endmodule

// File: rtl/dacseq_pinmux.sv
module dacseq_pinmux (
    input  logic active,
    input  logic dir_out,
    input  logic latch,
    input  logic pin_in,
    output logic pin_oe,
    output logic pin_do,
    output logic port_rd
);
    always_comb begin
        if (active) begin
            pin_oe  = 1'b0;
            pin_do  = 1'b0;
            port_rd = dir_out & latch;
        end else begin
            pin_oe  = dir_out;
            pin_do  = dir_out & latch;
            port_rd = dir_out ? latch : pin_in;
        end
    end
endmodule

// File: rtl/dac_output_sequencer.sv
module dac_output_sequencer
    import dacseq_pkg::*;
#(
    parameter int NCH        = 2,
    parameter int DW         = 12,
    parameter int WAIT_CYC   = 1000,
    parameter int SETTLE_CYC = 900
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    ch_en,
    input  logic [NCH-1:0]    ch_rt,
    input  logic [NCH-1:0]    wr_en,
    input  logic [NCH*DW-1:0] wr_data,
    input  logic [NCH-1:0]    trig,
    input  logic [NCH-1:0]    port_dir_out,
    input  logic [NCH-1:0]    port_latch,
    input  logic [NCH-1:0]    pin_in,
    output logic [NCH-1:0]    core_load,
    output logic [NCH*DW-1:0] core_data,
    output logic [NCH-1:0]    busy,
    output logic [NCH-1:0]    out_valid,
    output logic [NCH-1:0]    dac_active,
    output logic [NCH-1:0]    pin_oe,
    output logic [NCH-1:0]    pin_do,
    output logic [NCH-1:0]    port_rd
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ch_ctl_t   ctl;
        ch_state_e st;

        assign ctl.en   = ch_en[c];
        assign ctl.rt   = ch_rt[c];
        assign ctl.wr   = wr_en[c];
        assign ctl.trig = trig[c];

        dacseq_chan #(
            .DW        (DW),
            .WAIT_CYC  (WAIT_CYC),
            .SETTLE_CYC(SETTLE_CYC)
        ) u_chan (
            .clk      (clk),
            .rst      (rst),
            .ctl      (ctl),
            .wr_data  (wr_data[c*DW +: DW]),
            .state    (st),
            .core_load(core_load[c]),
            .core_data(core_data[c*DW +: DW]),
            .busy     (busy[c]),
            .out_valid(out_valid[c])
        );

        assign dac_active[c] = (st != CH_OFF);

        dacseq_pinmux u_pin (
            .active (dac_active[c]),
            .dir_out(port_dir_out[c]),
            .latch  (port_latch[c]),
            .pin_in (pin_in[c]),
            .pin_oe (pin_oe[c]),
            .pin_do (pin_do[c]),
            .port_rd(port_rd[c])
        );
    end
endmodule

// File: rtl/dacseq_chk.sv
module dacseq_chk #(
    parameter int NCH = 2,
    parameter int DW  = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [NCH-1:0]    ch_en,
    input logic [NCH-1:0]    wr_en,
    input logic [NCH*DW-1:0] wr_data,
    input logic [NCH-1:0]    core_load,
    input logic [NCH*DW-1:0] core_data,
    input logic [NCH-1:0]    busy,
    input logic [NCH-1:0]    out_valid,
    input logic [NCH-1:0]    dac_active,
    input logic [NCH-1:0]    pin_oe
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R5
        settle_then_valid_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(out_valid[i]) |-> $past(busy[i]))
            else $error("settle_then_valid_chk ch %0d", i);

        // R4
        load_begins_settle_chk: assert property (@(posedge clk) disable iff (rst)
            core_load[i] |-> (busy[i] && !out_valid[i]))
            else $error("load_begins_settle_chk ch %0d", i);

        // R2
        load_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
            core_load[i] |-> $past(ch_en[i]))
            else $error("load_needs_enable_chk ch %0d", i);

        // R8
        conflict_data_chk: assert property (@(posedge clk) disable iff (rst)
            (core_load[i] && $past(wr_en[i])) |->
                (core_data[i*DW +: DW] == $past(wr_data[i*DW +: DW])))
            else $error("conflict_data_chk ch %0d", i);

        // R10
        off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            !dac_active[i] |-> (!busy[i] && !out_valid[i]))
            else $error("off_quiet_chk ch %0d", i);

        // R11
        active_nodrive_chk: assert property (@(posedge clk) disable iff (rst)
            dac_active[i] |-> !pin_oe[i])
            else $error("active_nodrive_chk ch %0d", i);
    end
endmodule

bind dac_output_sequencer dacseq_chk #(.NCH(NCH), .DW(DW)) u_dacseq_chk (
    .clk       (clk),
    .rst       (rst),
    .ch_en     (ch_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .core_load (core_load),
    .core_data (core_data),
    .busy      (busy),
    .out_valid (out_valid),
    .dac_active(dac_active),
    .pin_oe    (pin_oe)
);

// File: tb/dac_output_sequencer_bench.sv
module dac_output_sequencer_bench;
    localparam int NCH = 2;
    localparam int DW  = 4;
    localparam int W   = 6;
    localparam int S   = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    ch_en = '0, ch_rt = '0, wr_en = '0, trig = '0;
    logic [NCH*DW-1:0] wr_data = '0;
    logic [NCH-1:0]    port_dir_out = '0, port_latch = '0, pin_in = '0;
    logic [NCH-1:0]    core_load, busy, out_valid, dac_active, pin_oe, pin_do, port_rd;
    logic [NCH*DW-1:0] core_data;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    dac_output_sequencer #(
        .NCH(NCH), .DW(DW), .WAIT_CYC(W), .SETTLE_CYC(S)
    ) u_dac_output_sequencer (
        .clk(clk), .rst(rst), .ch_en(ch_en), .ch_rt(ch_rt), .wr_en(wr_en),
        .wr_data(wr_data), .trig(trig), .port_dir_out(port_dir_out),
        .port_latch(port_latch), .pin_in(pin_in), .core_load(core_load),
        .core_data(core_data), .busy(busy), .out_valid(out_valid),
        .dac_active(dac_active), .pin_oe(pin_oe), .pin_do(pin_do), .port_rd(port_rd)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int cdata(input int ch);
        return int'(core_data[ch*DW +: DW]);
    endfunction

    task automatic measure_wait(input int ch, output int n);
        n = 0;
        for (int t = 0; t < 60; t++) begin
            tick();
            if (busy[ch]) n++;
            else if (n > 0) break;
        end
    endtask

    initial begin
        int n;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 core_load", int'(core_load), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 dac_active", int'(dac_active), 0);

        // R2 wait length on ch0, timer pulses ignored on ch1 (R13 as well)
        ch_rt = 2'b10;
        ch_en = 2'b11;
        trig[1] = 1'b1;
        for (int t = 1; t <= W + 1; t++) begin
            if (t == W + 1) trig[1] = 1'b0;
            tick();
            chk("R2 busy in wait ch0", int'(busy[0]), (t <= W) ? 1 : 0);
            chk("R2 no load in wait ch1", int'(core_load[1]), 0);
            chk("R2 no load in wait ch0", int'(core_load[0]), 0);
        end

        // R4 R5 software-paced sweep over every code
        for (int v = 0; v < (1 << DW); v++) begin
            wr_en[0] = 1'b1;
            wr_data[0 +: DW] = DW'(v);
            tick();
            wr_en[0] = 1'b0;
            chk("R4 load", int'(core_load[0]), 1);
            chk("R4 data", cdata(0), v);
            chk("R4 busy", int'(busy[0]), 1);
            chk("R13 ch1 idle", int'(core_load[1]), 0);
            for (int t = 1; t <= S; t++) begin
                tick();
                chk("R5 valid timing", int'(out_valid[0]), (t == S) ? 1 : 0);
            end
        end

        // R10 disable, then R3 held writes during wait
        ch_en[0] = 1'b0;
        tick();
        chk("R10 off valid", int'(out_valid[0]), 0);
        chk("R10 off busy", int'(busy[0]), 0);
        ch_en[0] = 1'b1;
        tick();
        wr_en[0] = 1'b1;
        wr_data[0 +: DW] = 4'd5;
        tick();
        wr_data[0 +: DW] = 4'd9;
        tick();
        wr_en[0] = 1'b0;
        for (int t = 4; t <= W; t++) begin
            tick();
            chk("R3 held no load", int'(core_load[0]), 0);
        end
        tick();
        chk("R3 load at wait end", int'(core_load[0]), 1);
        chk("R3 latest data", cdata(0), 9);
        repeat (S) tick();
        chk("R3 valid", int'(out_valid[0]), 1);

        // R9 enable 1,0,1 restarts wait from last rise
        ch_en[0] = 1'b0;
        tick();
        ch_en[0] = 1'b1;
        tick();
        tick();
        ch_en[0] = 1'b0;
        tick();
        ch_en[0] = 1'b1;
        measure_wait(0, n);
        chk("R9 full wait after re-enable", n, W);

        // R6 timer-paced: write starts nothing, trig converts stored code
        wr_en[1] = 1'b1;
        wr_data[DW +: DW] = 4'd3;
        tick();
        wr_en[1] = 1'b0;
        chk("R6 write no load", int'(core_load[1]), 0);
        trig[1] = 1'b1;
        tick();
        trig[1] = 1'b0;
        chk("R6 trig load", int'(core_load[1]), 1);
        chk("R6 trig data", cdata(1), 3);
        repeat (S) tick();
        chk("R6 valid", int'(out_valid[1]), 1);

        // R7 R8 second pulse at every offset, with same-cycle write
        for (int d = 1; d <= S + 2; d++) begin
            trig[1] = 1'b1;
            tick();
            trig[1] = 1'b0;
            chk("R7 first load", int'(core_load[1]), 1);
            for (int t = 1; t < d; t++) begin
                tick();
                chk("R7 valid before retrigger", int'(out_valid[1]), (t >= S) ? 1 : 0);
            end
            trig[1] = 1'b1;
            wr_en[1] = 1'b1;
            wr_data[DW +: DW] = DW'(d + 7);
            tick();
            trig[1] = 1'b0;
            wr_en[1] = 1'b0;
            chk("R7 restart load", int'(core_load[1]), 1);
            chk("R7 valid cleared", int'(out_valid[1]), 0);
            chk("R8 conflict data", cdata(1), (d + 7) % (1 << DW));
            chk("R13 ch0 no load", int'(core_load[0]), 0);
            for (int t = 1; t <= S; t++) begin
                tick();
                chk("R7 valid after restart", int'(out_valid[1]), (t == S) ? 1 : 0);
            end
        end

        // R10 R11 R12 pin ownership sweep: ch0 off, ch1 on
        ch_en[0] = 1'b0;
        tick();
        chk("R11 ch1 active", int'(dac_active[1]), 1);
        chk("R10 ch0 inactive", int'(dac_active[0]), 0);
        for (int k = 0; k < 8; k++) begin
            port_dir_out = {2{k[0]}};
            port_latch   = {2{k[1]}};
            pin_in       = {2{k[2]}};
            #1;
            chk("R10 off oe", int'(pin_oe[0]), k & 1);
            chk("R10 off do", int'(pin_do[0]), (k[0] && k[1]) ? 1 : 0);
            chk("R12 off read", int'(port_rd[0]), k[0] ? int'(k[1]) : int'(k[2]));
            chk("R11 on oe", int'(pin_oe[1]), 0);
            chk("R11 on read", int'(port_rd[1]), (k[0] && k[1]) ? 1 : 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule